// File: doc/BRIEF.md
# S/PDIF receiver lock and status-flag sequencer

This block sits behind a bi-phase decoder. It decides when decoded serial audio may leave the receiver, and it drives the stream-status flags. The receiver counts as locked only when the lock indication is high and all three preamble kinds (block start B, sub-frame M and sub-frame W) have been seen since that lock began. After that, an error flag stays high for a selectable hold time of 45, 100, 200 or 300 ms. Audio data passes only from the first frame-clock transition that follows the fall of the error flag. Until then the data output is forced to zero.

The non-PCM flag and the pre-emphasis flag come from channel-status bits. These bits are gathered over a complete 192-frame block that starts at a B preamble. The flags change once per completed block, with no regard to the error flag, so they are valid while audio is still muted.

The sequencer state machine has four states:
- `ST_SEEK`: not locked, error high.
- `ST_HOLD`: hold timer running, error high.
- `ST_ARM`: error low, waiting for a frame-clock edge, data muted.
- `ST_RUN`: data passing.

It has four forward transitions:
- SEEK→HOLD: lock is high and B, M and W have all been seen.
- HOLD→ARM: the hold time has expired.
- ARM→RUN: a frame-clock edge arrives.
- any→SEEK: the lock indication drops.

Top module: `spdif_lock_seq`

## Requirements
- R1: `err_flag` stays high until `pll_lock` is high and strobes on all of `pre_b`, `pre_m` and `pre_w` have been seen since `pll_lock` last rose. With one preamble kind missing, `err_flag` stays high indefinitely.
- R2: After the lock condition of R1 is met, `err_flag` stays high for a hold time and then falls. The hold time is H × CLK_PER_MS clock cycles, with a latency of one or two cycles. H is 45, 100, 200 or 300 ms for `hold_sel` = 0, 1, 2 or 3.
- R3: `sdata_out` is 0 while `err_flag` is high. It stays 0 after the fall of `err_flag` until the first transition of `frame_clk`, in either direction. From the cycle of that transition on, `sdata_out` equals `sdata_in`.
- R4: When `pll_lock` is low, `err_flag` is 1 and `sdata_out` is 0 in the same cycle. After lock returns, the full preamble search and the full hold time start again.
- R5: `nonpcm` equals channel-status bit 1 of the last completed block (0 = linear PCM, 1 = non-audio). When `or_sel` = 1 it is that bit ORed with `comp_det`. When `or_sel` = 0, `comp_det` has no effect.
- R6: When channel-status bit 0 = 0 (consumer format), `preemph` = 1 exactly when bits 3, 4 and 5 are 1, 0 and 0.
- R7: When channel-status bit 0 = 1 (professional format), `preemph` = 1 exactly when bits 2, 3 and 4 are 1, 1 and 0.
- R8: Channel-status bit n is the `cs_bit` given with the n-th `cs_strobe` of a block. Frame 0 is the strobe given together with `pre_b`. The flags take new values one cycle after the 192nd strobe of a block, even while `err_flag` is high. A block that ends before 192 frames leaves the flags unchanged.
- R9: During and after reset, `err_flag` = 1, `sdata_out` = 0, `nonpcm` = 0 and `preemph` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also the time base of the hold timer |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_lock | input | 1 | Lock indication from the clock recovery |
| pre_b | input | 1 | B preamble strobe (block start) |
| pre_m | input | 1 | M preamble strobe |
| pre_w | input | 1 | W preamble strobe |
| cs_strobe | input | 1 | One pulse per frame carrying a channel-status bit |
| cs_bit | input | 1 | Channel-status bit of the current frame |
| comp_det | input | 1 | Compressed-stream detect flag |
| or_sel | input | 1 | Selects OR of `comp_det` into `nonpcm` |
| hold_sel | input | 2 | Hold-time select (45/100/200/300 ms) |
| frame_clk | input | 1 | Recovered left/right frame clock, synchronous to `clk` |
| sdata_in | input | 1 | Serial audio data from the formatter |
| err_flag | output | 1 | Receive error / not-ready flag |
| sdata_out | output | 1 | Gated serial audio data |
| nonpcm | output | 1 | Non-PCM stream flag |
| preemph | output | 1 | 50/15 µs pre-emphasis flag |

## Verification
Lock is tried with preamble sets that lack one kind and with complete sets, each under every `hold_sel` code. The measured high time of `err_flag` shows whether the timer and the select mapping are right. The release of data is probed by holding `frame_clk` still after the error falls and then toggling it. This shows whether output starts on the edge or on the fall of the error flag. Random channel-status words, with directed consumer and professional emphasis codes and random `or_sel`/`comp_det`, separate the two format decoders and the OR path. Short blocks and blocks sent while unlocked show that flags change only on block completion and never wait for the error flag.

// File: rtl/spdif_seq_pkg.sv
package spdif_seq_pkg;

    localparam int MS_W     = 9;
    localparam int CS_KEEP  = 6;

    typedef enum logic [1:0] {
        ST_SEEK = 2'd0,
        ST_HOLD = 2'd1,
        ST_ARM  = 2'd2,
        ST_RUN  = 2'd3
    } seq_state_t;

    function automatic logic [MS_W-1:0] hold_ms(input logic [1:0] sel);
        unique case (sel)
            2'd0:    hold_ms = MS_W'(45);
            2'd1:    hold_ms = MS_W'(100);
            2'd2:    hold_ms = MS_W'(200);
            default: hold_ms = MS_W'(300);
        endcase
    endfunction

endpackage

// File: rtl/spdif_lock_fsm.sv
module spdif_lock_fsm
    import spdif_seq_pkg::*;
#(
    parameter int CLK_PER_MS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pll_lock,
    input  logic       pre_b,
    input  logic       pre_m,
    input  logic       pre_w,
    input  logic [1:0] hold_sel,
    input  logic       frame_edge,
    output logic       err_o,
    output logic       pass_o
);

    localparam int PRE_W = $clog2(CLK_PER_MS + 1);

    seq_state_t        st, st_nx;
    logic [2:0]        seen;
    logic [PRE_W-1:0]  pre_cnt;
    logic [MS_W-1:0]   ms_cnt;
    logic [MS_W-1:0]   ms_lim;
    logic              pre_wrap;
    logic              hold_done;

    assign ms_lim    = hold_ms(hold_sel);
    assign pre_wrap  = (pre_cnt == PRE_W'(CLK_PER_MS - 1));
    assign hold_done = pre_wrap && (ms_cnt == ms_lim - MS_W'(1));

    // preamble record, cleared whenever lock is absent
    always_ff @(posedge clk) begin
        if (!rst_n || !pll_lock) begin
            seen <= 3'b000;
        end else begin
            seen <= seen | {pre_b, pre_m, pre_w};
        end
    end

    // hold timer: clock prescaler to milliseconds, then millisecond count
    always_ff @(posedge clk) begin
        if (!rst_n || st != ST_HOLD) begin
            pre_cnt <= '0;
            ms_cnt  <= '0;
        end else if (pre_wrap) begin
            pre_cnt <= '0;
            ms_cnt  <= ms_cnt + MS_W'(1);
        end else begin
            pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_SEEK;
        end else begin
            st <= st_nx;
        end
    end

    // transitions
    always_comb begin
        st_nx = st;
        if (!pll_lock) begin
            st_nx = ST_SEEK;
        end else begin
            unique case (st)
                ST_SEEK: if (&seen)      st_nx = ST_HOLD;
                ST_HOLD: if (hold_done)  st_nx = ST_ARM;
                ST_ARM:  if (frame_edge) st_nx = ST_RUN;
                ST_RUN:                  st_nx = ST_RUN;
                default:                 st_nx = ST_SEEK;
            endcase
        end
    end

    // outputs
    always_comb begin
        err_o  = 1'b1;
        pass_o = 1'b0;
        unique case (st)
            ST_SEEK: begin err_o = 1'b1; pass_o = 1'b0; end
            ST_HOLD: begin err_o = 1'b1; pass_o = 1'b0; end
            ST_ARM:  begin err_o = !pll_lock; pass_o = pll_lock && frame_edge; end
            ST_RUN:  begin err_o = !pll_lock; pass_o = pll_lock; end
            default: begin err_o = 1'b1; pass_o = 1'b0; end
        endcase
    end

endmodule

// File: rtl/spdif_cs_capture.sv
module spdif_cs_capture
    import spdif_seq_pkg::*;
#(
    parameter int FRAMES = 192
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_strobe,
    input  logic               cs_bit,
    input  logic               blk_start,
    output logic [CS_KEEP-1:0] cs_word
);

    localparam int FC_W = $clog2(FRAMES + 1);

    logic [FC_W-1:0]    fcnt;
    logic [FC_W-1:0]    idx;
    logic               in_blk;
    logic               active;
    logic [CS_KEEP-1:0] shadow;
    logic [CS_KEEP-1:0] shadow_nx;

    assign idx    = blk_start ? '0 : fcnt;
    assign active = cs_strobe && (in_blk || blk_start);

    // shadow with the bit of this frame merged in
    always_comb begin
        shadow_nx = shadow;
        for (int i = 0; i < CS_KEEP; i++) begin
            if (idx == FC_W'(i)) shadow_nx[i] = cs_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt    <= '0;
            in_blk  <= 1'b0;
            shadow  <= '0;
            cs_word <= '0;
        end else if (active) begin
            shadow <= shadow_nx;
            if (idx == FC_W'(FRAMES - 1)) begin
                cs_word <= shadow_nx;
                in_blk  <= 1'b0;
                fcnt    <= '0;
            end else begin
                in_blk  <= 1'b1;
                fcnt    <= idx + FC_W'(1);
            end
        end
    end

endmodule

// File: rtl/spdif_flag_decode.sv
module spdif_flag_decode
    import spdif_seq_pkg::*;
(
    input  logic [CS_KEEP-1:0] cs_word,
    input  logic               or_sel,
    input  logic               comp_det,
    output logic               nonpcm,
    output logic               preemph
);

    logic cons_emph;
    logic pro_emph;

    assign cons_emph = ({cs_word[3], cs_word[4], cs_word[5]} == 3'b100);
    assign pro_emph  = ({cs_word[2], cs_word[3], cs_word[4]} == 3'b110);

    always_comb begin
        nonpcm  = cs_word[1] | (or_sel & comp_det);
        preemph = cs_word[0] ? pro_emph : cons_emph;
    end

endmodule

// File: rtl/spdif_lock_seq.sv
module spdif_lock_seq
    import spdif_seq_pkg::*;
#(
    parameter int CLK_PER_MS = 16,
    parameter int FRAMES     = 192
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pll_lock,
    input  logic       pre_b,
    input  logic       pre_m,
    input  logic       pre_w,
    input  logic       cs_strobe,
    input  logic       cs_bit,
    input  logic       comp_det,
    input  logic       or_sel,
    input  logic [1:0] hold_sel,
    input  logic       frame_clk,
    input  logic       sdata_in,
    output logic       err_flag,
    output logic       sdata_out,
    output logic       nonpcm,
    output logic       preemph
);

    logic               fclk_q;
    logic               frame_edge;
    logic               pass;
    logic [CS_KEEP-1:0] cs_word;

    always_ff @(posedge clk) begin
        if (!rst_n) fclk_q <= 1'b0;
        else        fclk_q <= frame_clk;
    end

    assign frame_edge = frame_clk ^ fclk_q;

    spdif_lock_fsm #(.CLK_PER_MS(CLK_PER_MS)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pll_lock   (pll_lock),
        .pre_b      (pre_b),
        .pre_m      (pre_m),
        .pre_w      (pre_w),
        .hold_sel   (hold_sel),
        .frame_edge (frame_edge),
        .err_o      (err_flag),
        .pass_o     (pass)
    );

    spdif_cs_capture #(.FRAMES(FRAMES)) i_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_strobe (cs_strobe),
        .cs_bit    (cs_bit),
        .blk_start (pre_b),
        .cs_word   (cs_word)
    );

    spdif_flag_decode i_dec (
        .cs_word  (cs_word),
        .or_sel   (or_sel),
        .comp_det (comp_det),
        .nonpcm   (nonpcm),
        .preemph  (preemph)
    );

    assign sdata_out = pass & sdata_in;

endmodule

// File: rtl/spdif_lock_seq_chk.sv
module spdif_lock_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic pll_lock,
    input logic cs_strobe,
    input logic comp_det,
    input logic or_sel,
    input logic err_flag,
    input logic sdata_out,
    input logic nonpcm,
    input logic preemph
);

    // R4: unlock forces error and mute in the same cycle
    p_unlock_mute_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_lock |-> (err_flag && !sdata_out));

    // R3: no data while error is high
    p_data_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> !sdata_out);

    // R1: error only falls with lock held
    p_err_fall_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_flag) |-> (pll_lock && $past(pll_lock)));

    // R8: emphasis flag moves only right after a frame strobe
    p_emph_on_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(preemph) |-> $past(cs_strobe));

    // R5: compressed detect forces non-PCM when selected
    p_nonpcm_or_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (or_sel && comp_det) |-> nonpcm);

endmodule

bind spdif_lock_seq spdif_lock_seq_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pll_lock  (pll_lock),
    .cs_strobe (cs_strobe),
    .comp_det  (comp_det),
    .or_sel    (or_sel),
    .err_flag  (err_flag),
    .sdata_out (sdata_out),
    .nonpcm    (nonpcm),
    .preemph   (preemph)
);

// File: tb/test_spdif_lock_seq.sv
`timescale 1ns/1ps
module test_spdif_lock_seq;

    localparam int CPM = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pll_lock = 1'b0, pre_b = 1'b0, pre_m = 1'b0, pre_w = 1'b0;
    logic cs_strobe = 1'b0, cs_bit = 1'b0, comp_det = 1'b0, or_sel = 1'b0;
    logic [1:0] hold_sel = 2'd0;
    logic frame_clk = 1'b0, sdata_in = 1'b0;
    logic err_flag, sdata_out, nonpcm, preemph;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] cur_word = 8'h00;

    always #5 clk = ~clk;

    spdif_lock_seq #(.CLK_PER_MS(CPM), .FRAMES(192)) i_spdif_lock_seq (
        .clk(clk), .rst_n(rst_n), .pll_lock(pll_lock),
        .pre_b(pre_b), .pre_m(pre_m), .pre_w(pre_w),
        .cs_strobe(cs_strobe), .cs_bit(cs_bit), .comp_det(comp_det),
        .or_sel(or_sel), .hold_sel(hold_sel), .frame_clk(frame_clk),
        .sdata_in(sdata_in), .err_flag(err_flag), .sdata_out(sdata_out),
        .nonpcm(nonpcm), .preemph(preemph)
    );

    function automatic int exp_hold(input logic [1:0] s);
        case (s)
            2'd0: return 45;
            2'd1: return 100;
            2'd2: return 200;
            default: return 300;
        endcase
    endfunction

    function automatic logic exp_nonpcm(input logic [7:0] w, input logic os, input logic cd);
        return w[1] | (os & cd);
    endfunction

    function automatic logic exp_emph(input logic [7:0] w);
        if (w[0] == 1'b0) return (w[3] && !w[4] && !w[5]);
        return (w[2] && w[3] && !w[4]);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        pre_b = (which == 0); pre_m = (which == 1); pre_w = (which == 2);
        @(negedge clk);
        pre_b = 0; pre_m = 0; pre_w = 0;
    endtask

    // send n frames; word bits for frames 0..7, random bits beyond
    task automatic send_block(input logic [7:0] w, input int n);
        for (int f = 0; f < n; f++) begin
            @(negedge clk);
            cs_strobe = 1'b1;
            cs_bit = (f < 8) ? w[f] : 1'($urandom);
            pre_b = (f == 0);
            @(negedge clk);
            cs_strobe = 1'b0;
            pre_b = 1'b0;
        end
        @(negedge clk);
        #1;
    endtask

    task automatic check_flags(input string tag);
        chk({tag, " R5 nonpcm"}, nonpcm, exp_nonpcm(cur_word, or_sel, comp_det));
        chk({tag, " R6/R7 preemph"}, preemph, exp_emph(cur_word));
    endtask

    // relock with hold code s and measure error high time
    task automatic lock_and_measure(input logic [1:0] s);
        int cnt;
        int n;
        hold_sel = s;
        @(negedge clk); pll_lock = 0;
        @(negedge clk); pll_lock = 1;
        pulse(0); pulse(1);
        @(negedge clk);
        pre_w = 1;
        @(negedge clk);
        pre_w = 0;
        cnt = 1;
        #1;
        while (err_flag && cnt < 6000) begin
            @(negedge clk); #1; cnt++;
        end
        n = exp_hold(s) * CPM;
        chk_int("R2 hold time", cnt, n + 1, n + 3);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        #1;
        chk("R9 err in reset", err_flag, 1'b1);
        chk("R9 data in reset", sdata_out, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R9 err after reset", err_flag, 1'b1);
        chk("R9 nonpcm after reset", nonpcm, 1'b0);
        chk("R9 preemph after reset", preemph, 1'b0);

        // R8: block completes while unlocked; flags update with err high
        cur_word = 8'b0000_1010;  // consumer, non-audio, emphasis 1,0,0
        send_block(cur_word, 192);
        check_flags("R8 while err");
        chk("R8 err still high", err_flag, 1'b1);

        // R1: missing W keeps error high
        pll_lock = 1; sdata_in = 1;
        pulse(0); pulse(1);
        repeat (2000) @(negedge clk);
        #1;
        chk("R1 no W err high", err_flag, 1'b1);
        chk("R1 no W data muted", sdata_out, 1'b0);

        // R2 and R3
        lock_and_measure(2'd0);
        repeat (5) @(negedge clk);
        #1;
        chk("R3 muted before edge", sdata_out, 1'b0);
        chk("R3 err low", err_flag, 1'b0);
        @(negedge clk); frame_clk = ~frame_clk; #1;
        chk("R3 data on edge", sdata_out, 1'b1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); sdata_in = 1'($urandom);
            if (i % 4 == 0) frame_clk = ~frame_clk;
            #1;
            chk("R3 data follows", sdata_out, sdata_in);
        end

        // R4: loss of lock
        @(negedge clk); sdata_in = 1; pll_lock = 0; #1;
        chk("R4 err on unlock", err_flag, 1'b1);
        chk("R4 data muted on unlock", sdata_out, 1'b0);
        @(negedge clk); pll_lock = 1;
        repeat (50) @(negedge clk);
        #1;
        chk("R4 err stays after relock", err_flag, 1'b1);

        for (int s = 1; s < 4; s++) lock_and_measure(2'(s));
        // falling frame edge also releases
        repeat (3) @(negedge clk);
        #1;
        chk("R3 muted before edge 2", sdata_out, 1'b0);
        @(negedge clk); frame_clk = ~frame_clk; #1;
        chk("R3 data on edge 2", sdata_out, 1'b1);

        // R7 professional emphasis, R6 consumer with pro pattern
        cur_word = 8'b0000_1101; send_block(cur_word, 192); check_flags("R7 pro emph");
        cur_word = 8'b0001_1101; send_block(cur_word, 192); check_flags("R7 pro no emph");
        cur_word = 8'b0000_1100; send_block(cur_word, 192); check_flags("R6 cons other");
        cur_word = 8'b0000_1000; send_block(cur_word, 192); check_flags("R6 cons emph");

        // R5: comp_det ignored without select, ORed with it
        comp_det = 1; or_sel = 0; #1; check_flags("R5 sel off");
        or_sel = 1; #1; check_flags("R5 sel on");
        comp_det = 0; or_sel = 0;

        // R8: short block leaves flags unchanged
        send_block(~cur_word, 100);
        check_flags("R8 short block");

        for (int k = 0; k < 20; k++) begin
            cur_word = 8'($urandom);
            if (k % 3 == 0) cur_word[0] = 1'b0;
            or_sel = 1'($urandom);
            comp_det = 1'($urandom);
            send_block(cur_word, 192);
            check_flags("R5 R6 R7 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule